// File: doc/BRIEF.md
# SD Card Data Block Transfer Engine

This engine moves the data phase of an SD card transfer once a data command has been issued. It works in either single-line mode on DAT0 or four-line mode on DAT3..DAT0. Every block goes out or comes in as a start bit, the payload, a 16-bit CRC on each active line and an end bit.

On a read, the engine waits for the card's start bit and assembles the payload into bytes. Each byte goes out on a one-cycle strobe, and the engine checks every line's CRC. On a write, the engine waits a programmed number of idle bus clocks, then pulls bytes from a first-word-fall-through source and sends them. It then releases the bus, reads the card's 3-bit CRC status token, and waits while the card holds DAT0 low.

A repeat field sets the number of blocks. Once the transfer ends, one flag per direction reports whether every block was error-free. The bus clock is not generated here. A one-cycle `bus_tick` enable marks each bus clock period, and all bus activity moves only on those cycles.

Top module: `sdblk_engine`

## Requirements
- R1: A transfer moves `cfg_rep_m1`+1 blocks. `done` pulses for one cycle at the bus clock that closes the last block, and `busy` is low from that cycle on.
- R2: `cfg_len_bits` is programmed as payload bytes × 8 + 15 × W, where W is 1 in single-line mode and 4 in four-line mode. Each active line then carries (`cfg_len_bits` − 15·W)/W payload bits per block.
- R3: With `cfg_wide`=0, only DAT0 carries data, each byte MSB first, and `dat_oe` is 4'b0001 while driving.
- R4: With `cfg_wide`=1, each byte is sent as its high nibble and then its low nibble. Nibble bit i is on DAT i, and `dat_oe` is 4'b1111 while driving.
- R5: Each written block is framed as a start bit 0 and the payload, then 16 CRC bits per active line, MSB first, and then an end bit 1. The CRC uses x^16+x^12+x^5+1 with an initial value of zero over that line's payload bits.
- R6: A read waits for DAT0 low as the start bit. Each completed payload byte appears on `rd_data` with a one-cycle `rd_valid`, in arrival order.
- R7: After a read, `rd_crc_ok` is 1 only if every active line's received CRC matched in every block. Both flags are 0 while `busy` is high and hold their value after `done` until the next start.
- R8: Before each written block, the engine leaves the bus undriven for exactly `cfg_gap` bus clocks and then drives the start bit.
- R9: After a written block's end bit, the engine releases the bus. It waits for a start bit 0 on DAT0, takes the next 3 DAT0 bits MSB first as a token, and compares it with `cfg_tok_exp`. `wr_crc_ok` is 1 after a write only if every token matched.
- R10: After the token's end bit, the engine waits while DAT0 is low. It starts the next block's gap, or finishes, at the first bus clock where DAT0 is high.
- R11: Bus outputs and the transfer state move only in cycles with `bus_tick` high. `wr_pop` is high only in such cycles and exactly once per payload byte, and `wr_data` is taken in that cycle.
- R12: After reset, `busy`, `dat_oe`, `done`, `rd_valid` and both flags are 0, and `dat_out` is 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| cfg_write | input | 1 | 1 = write to card, 0 = read from card |
| cfg_wide | input | 1 | 0 = DAT0 only, 1 = DAT3..DAT0 |
| cfg_rep_m1 | input | 8 | Block count minus one |
| cfg_len_bits | input | 14 | Payload bits plus 15 × line count |
| cfg_gap | input | 6 | Idle bus clocks before each written block |
| cfg_tok_exp | input | 3 | Expected write status token |
| bus_tick | input | 1 | One-cycle enable per bus clock period |
| dat_in | input | 4 | Sampled data lines |
| dat_out | output | 4 | Driven data line values |
| dat_oe | output | 4 | Per-line output enable |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` strobe |
| wr_data | input | 8 | Byte to send (valid when popped) |
| wr_pop | output | 1 | Consumes `wr_data` this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_crc_ok | output | 1 | All read CRCs matched |
| wr_crc_ok | output | 1 | All write tokens matched |

## Verification
The hardest cases to reach are a CRC error confined to one line of one block in the middle of a multi-block read, and a single bad token in the middle of a multi-block write. Both must still clear the final flag while every other block runs normally. The bench acts as the card. It computes each line's CRC arithmetically and flips one chosen CRC bit on one chosen line in one chosen block. On writes it returns a wrong token for one chosen block and holds DAT0 busy for a varying number of clocks. The sweep covers both widths, several block sizes and repeat counts, and gaps that include zero.

// File: rtl/sdblk_pkg.sv
package sdblk_pkg;

    localparam int LANES    = 4;
    localparam int LANE_SH  = $clog2(LANES);
    localparam int CRC_W    = 16;
    localparam int CRC_M1   = CRC_W - 1;
    localparam int LEN_W    = 14;
    localparam int REP_W    = 8;
    localparam int GAP_W    = 6;
    localparam int TOK_W    = 3;
    localparam int BYTE_W   = 8;
    localparam int BCNT_W   = $clog2(BYTE_W);

    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_GAP,
        ST_W_START,
        ST_W_DATA,
        ST_W_CRC,
        ST_W_END,
        ST_W_TOKWAIT,
        ST_W_TOK,
        ST_W_TOKEND,
        ST_W_BUSY,
        ST_R_WAIT,
        ST_R_DATA,
        ST_R_CRC,
        ST_R_END
    } xfer_state_t;

    typedef struct packed {
        logic             wide;
        logic [GAP_W-1:0] gap;
        logic [TOK_W-1:0] tok_exp;
    } xfer_cfg_t;

    // payload bus clocks per line for one block
    function automatic logic [LEN_W-1:0] payload_ticks(input logic [LEN_W-1:0] len,
                                                       input logic wide);
        logic [LEN_W-1:0] crc_bits;
        crc_bits = wide ? LEN_W'(CRC_M1 * LANES) : LEN_W'(CRC_M1);
        return wide ? ((len - crc_bits) >> LANE_SH) : (len - crc_bits);
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic wide);
        return wide ? {LANES{1'b1}} : LANES'(1);
    endfunction

    // index of the last bus clock inside one byte
    function automatic logic [BCNT_W-1:0] byte_last(input logic wide);
        return wide ? BCNT_W'(BYTE_W / LANES - 1) : BCNT_W'(BYTE_W - 1);
    endfunction

endpackage

// File: rtl/sdblk_crc16.sv
module sdblk_crc16
    import sdblk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc
);
    logic             fb;
    logic [CRC_W-1:0] crc_nx;

    always_comb begin
        fb     = bit_in ^ crc[CRC_W-1];
        crc_nx = {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) crc <= '0;
        else if (en)    crc <= crc_nx;
    end
endmodule

// File: rtl/sdblk_shifter.sv
module sdblk_shifter
    import sdblk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              load,
    input  logic [BYTE_W-1:0] ld_byte,
    input  logic              shift,
    input  logic [LANES-1:0]  ser_in,
    output logic [BYTE_W-1:0] q_next,
    output logic [LANES-1:0]  out_bits
);
    logic [BYTE_W-1:0] sh;

    always_comb begin
        if (wide) begin
            q_next   = {sh[BYTE_W-LANES-1:0], ser_in};
            out_bits = sh[BYTE_W-1 -: LANES];
        end else begin
            q_next   = {sh[BYTE_W-2:0], ser_in[0]};
            out_bits = {{(LANES-1){1'b1}}, sh[BYTE_W-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        sh <= '0;
        else if (load)  sh <= ld_byte;
        else if (shift) sh <= q_next;
    end
endmodule

// File: rtl/sdblk_engine.sv
module sdblk_engine
    import sdblk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cfg_write,
    input  logic              cfg_wide,
    input  logic [REP_W-1:0]  cfg_rep_m1,
    input  logic [LEN_W-1:0]  cfg_len_bits,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic [TOK_W-1:0]  cfg_tok_exp,
    input  logic              bus_tick,
    input  logic [LANES-1:0]  dat_in,
    output logic [LANES-1:0]  dat_out,
    output logic [LANES-1:0]  dat_oe,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wr_pop,
    output logic              busy,
    output logic              done,
    output logic              rd_crc_ok,
    output logic              wr_crc_ok
);
    xfer_state_t       state;
    xfer_cfg_t         cfg;
    logic [LEN_W-1:0]  dticks;
    logic [LEN_W-1:0]  tcnt;
    logic [BCNT_W-1:0] bcnt;
    logic [REP_W-1:0]  blk_left;
    logic [TOK_W-2:0]  tok_sh;
    logic              err;

    logic [LANES-1:0]  sh_out;
    logic [BYTE_W-1:0] sh_next;
    logic [LANES-1:0]  tx_bits;
    logic [LANES-1:0]  lane_bits;
    logic [LANES-1:0]  crc_msb;
    logic [LANES-1:0]  crc_zero;
    logic [TOK_W-1:0]  tok_full;
    logic              crc_en, crc_clr, sh_shift;
    logic              byte_end, data_end, crc_end, last_blk, blk_bad, rx_phase;

    // per-line CRC16 generators
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [CRC_W-1:0] crc_q;
        sdblk_crc16 u_crc (
            .clk    (clk),
            .rst    (rst),
            .clr    (crc_clr),
            .en     (crc_en),
            .bit_in (lane_bits[l]),
            .crc    (crc_q)
        );
        assign crc_msb[l]  = crc_q[CRC_W-1];
        assign crc_zero[l] = (crc_q == '0);
    end

    sdblk_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .wide     (cfg.wide),
        .load     (wr_pop),
        .ld_byte  (wr_data),
        .shift    (sh_shift),
        .ser_in   (dat_in),
        .q_next   (sh_next),
        .out_bits (sh_out)
    );

    always_comb begin
        rx_phase = (state == ST_R_DATA) || (state == ST_R_CRC);
        case (state)
            ST_W_DATA: tx_bits = sh_out;
            ST_W_CRC:  tx_bits = crc_msb;
            default:   tx_bits = '1;
        endcase
        lane_bits = rx_phase ? dat_in : tx_bits;
        crc_en    = bus_tick && (rx_phase || (state == ST_W_DATA) || (state == ST_W_CRC));
        crc_clr   = bus_tick && ((state == ST_W_START) ||
                                 ((state == ST_R_WAIT) && !dat_in[0]));
        byte_end  = (bcnt == byte_last(cfg.wide));
        data_end  = (tcnt == dticks - LEN_W'(1));
        crc_end   = (tcnt == LEN_W'(CRC_M1));
        last_blk  = (blk_left == '0);
        wr_pop    = bus_tick && ((state == ST_W_START) ||
                                 ((state == ST_W_DATA) && byte_end && !data_end));
        sh_shift  = bus_tick && ((state == ST_W_DATA) || (state == ST_R_DATA)) && !wr_pop;
        blk_bad   = |(lane_mask(cfg.wide) & ~crc_zero);
        tok_full  = {tok_sh, dat_in[0]};
        busy      = (state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cfg       <= '0;
            dticks    <= '0;
            tcnt      <= '0;
            bcnt      <= '0;
            blk_left  <= '0;
            tok_sh    <= '0;
            err       <= 1'b0;
            dat_out   <= '1;
            dat_oe    <= '0;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            done      <= 1'b0;
            rd_crc_ok <= 1'b0;
            wr_crc_ok <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            if (state == ST_IDLE) begin
                if (start) begin
                    cfg.wide    <= cfg_wide;
                    cfg.gap     <= cfg_gap;
                    cfg.tok_exp <= cfg_tok_exp;
                    dticks      <= payload_ticks(cfg_len_bits, cfg_wide);
                    blk_left    <= cfg_rep_m1;
                    err         <= 1'b0;
                    rd_crc_ok   <= 1'b0;
                    wr_crc_ok   <= 1'b0;
                    tcnt        <= '0;
                    if (!cfg_write)          state <= ST_R_WAIT;
                    else if (cfg_gap == '0)  state <= ST_W_START;
                    else                     state <= ST_W_GAP;
                end
            end else if (bus_tick) begin
                case (state)
                    ST_W_GAP: begin
                        if (tcnt == LEN_W'(cfg.gap) - LEN_W'(1)) begin
                            tcnt  <= '0;
                            state <= ST_W_START;
                        end else begin
                            tcnt <= tcnt + LEN_W'(1);
                        end
                    end
                    ST_W_START: begin
                        dat_out <= ~lane_mask(cfg.wide);
                        dat_oe  <= lane_mask(cfg.wide);
                        bcnt    <= '0;
                        tcnt    <= '0;
                        state   <= ST_W_DATA;
                    end
                    ST_W_DATA: begin
                        dat_out <= tx_bits;
                        bcnt    <= byte_end ? '0 : bcnt + BCNT_W'(1);
                        if (data_end) begin
                            tcnt  <= '0;
                            state <= ST_W_CRC;
                        end else begin
                            tcnt <= tcnt + LEN_W'(1);
                        end
                    end
                    ST_W_CRC: begin
                        dat_out <= tx_bits;
                        if (crc_end) begin
                            tcnt  <= '0;
                            state <= ST_W_END;
                        end else begin
                            tcnt <= tcnt + LEN_W'(1);
                        end
                    end
                    ST_W_END: begin
                        dat_out <= '1;
                        state   <= ST_W_TOKWAIT;
                    end
                    ST_W_TOKWAIT: begin
                        dat_oe <= '0;
                        if (!dat_in[0]) begin
                            tcnt  <= '0;
                            state <= ST_W_TOK;
                        end
                    end
                    ST_W_TOK: begin
                        tok_sh <= tok_full[TOK_W-2:0];
                        if (tcnt == LEN_W'(TOK_W - 1)) begin
                            if (tok_full != cfg.tok_exp) err <= 1'b1;
                            state <= ST_W_TOKEND;
                        end else begin
                            tcnt <= tcnt + LEN_W'(1);
                        end
                    end
                    ST_W_TOKEND: state <= ST_W_BUSY;
                    ST_W_BUSY: begin
                        if (dat_in[0]) begin
                            if (last_blk) begin
                                state     <= ST_IDLE;
                                done      <= 1'b1;
                                wr_crc_ok <= !err;
                            end else begin
                                blk_left <= blk_left - REP_W'(1);
                                tcnt     <= '0;
                                state    <= (cfg.gap == '0) ? ST_W_START : ST_W_GAP;
                            end
                        end
                    end
                    ST_R_WAIT: begin
                        if (!dat_in[0]) begin
                            tcnt  <= '0;
                            bcnt  <= '0;
                            state <= ST_R_DATA;
                        end
                    end
                    ST_R_DATA: begin
                        bcnt <= byte_end ? '0 : bcnt + BCNT_W'(1);
                        if (byte_end) begin
                            rd_valid <= 1'b1;
                            rd_data  <= sh_next;
                        end
                        if (data_end) begin
                            tcnt  <= '0;
                            state <= ST_R_CRC;
                        end else begin
                            tcnt <= tcnt + LEN_W'(1);
                        end
                    end
                    ST_R_CRC: begin
                        if (crc_end) begin
                            tcnt  <= '0;
                            state <= ST_R_END;
                        end else begin
                            tcnt <= tcnt + LEN_W'(1);
                        end
                    end
                    ST_R_END: begin
                        err <= err | blk_bad;
                        if (last_blk) begin
                            state     <= ST_IDLE;
                            done      <= 1'b1;
                            rd_crc_ok <= !(err | blk_bad);
                        end else begin
                            blk_left <= blk_left - REP_W'(1);
                            state    <= ST_R_WAIT;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdblk_engine_chk.sv
module sdblk_engine_chk
    import sdblk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_tick,
    input logic             busy,
    input logic             done,
    input logic             rd_valid,
    input logic             wr_pop,
    input logic             rd_crc_ok,
    input logic             wr_crc_ok,
    input logic [LANES-1:0] dat_out,
    input logic [LANES-1:0] dat_oe,
    input logic             lane_wide
);
    // R3
    oe_narrow_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !lane_wide) |-> (dat_oe[LANES-1:1] == '0));

    // R11
    pop_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pop |-> bus_tick);

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_tick |=> ($stable(dat_out) && $stable(dat_oe)));

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R6
    no_mix_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && wr_pop));

    // R7
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_crc_ok && wr_crc_ok));

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!rd_crc_ok && !wr_crc_ok));

    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind sdblk_engine sdblk_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_tick  (bus_tick),
    .busy      (busy),
    .done      (done),
    .rd_valid  (rd_valid),
    .wr_pop    (wr_pop),
    .rd_crc_ok (rd_crc_ok),
    .wr_crc_ok (wr_crc_ok),
    .dat_out   (dat_out),
    .dat_oe    (dat_oe),
    .lane_wide (cfg.wide)
);

// File: tb/sdblk_engine_bench.sv
module sdblk_engine_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       cfg_write = 1'b0;
    logic       cfg_wide = 1'b0;
    logic [7:0] cfg_rep_m1 = '0;
    logic [13:0] cfg_len_bits = '0;
    logic [5:0] cfg_gap = '0;
    logic [2:0] cfg_tok_exp = 3'b010;
    logic       bus_tick = 1'b0;
    logic [3:0] dat_in = 4'hF;
    logic [3:0] dat_out, dat_oe;
    logic [7:0] rd_data, wr_data;
    logic       rd_valid, wr_pop, busy, done, rd_crc_ok, wr_crc_ok;

    logic [7:0] wmem [0:15];
    int         widx = 0;
    logic [7:0] blk_b [0:3];
    int         n_chk = 0;
    int         n_bad = 0;
    bit         finished = 0;

    logic [3:0] s_out, s_oe;
    logic [7:0] s_rd;
    logic       s_rv, s_done, s_busy;

    assign wr_data = wmem[widx];

    always #10 clk = ~clk;

    sdblk_engine u_sdblk_engine (
        .clk(clk), .rst(rst), .start(start), .cfg_write(cfg_write), .cfg_wide(cfg_wide),
        .cfg_rep_m1(cfg_rep_m1), .cfg_len_bits(cfg_len_bits), .cfg_gap(cfg_gap),
        .cfg_tok_exp(cfg_tok_exp), .bus_tick(bus_tick), .dat_in(dat_in),
        .dat_out(dat_out), .dat_oe(dat_oe), .rd_data(rd_data), .rd_valid(rd_valid),
        .wr_data(wr_data), .wr_pop(wr_pop), .busy(busy), .done(done),
        .rd_crc_ok(rd_crc_ok), .wr_crc_ok(wr_crc_ok)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
        return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
    endfunction

    function automatic logic line_bit(input bit w, input int t, input int l);
        logic [7:0] by;
        if (w) begin
            by = blk_b[t / 2];
            return (t % 2 == 0) ? by[4 + l] : by[l];
        end
        if (l != 0) return 1'b1;
        by = blk_b[t / 8];
        return by[7 - (t % 8)];
    endfunction

    function automatic logic [7:0] gen(input int seed, input int b, input int i);
        return 8'(seed * 17 + b * 53 + i * 29 + 8'h3C);
    endfunction

    task automatic tick();
        bit pop_seen;
        @(negedge clk);
        bus_tick = 1'b1;
        #1;
        pop_seen = wr_pop;
        @(posedge clk);
        #1;
        bus_tick = 1'b0;
        if (pop_seen) widx++;
        @(negedge clk);
        s_out = dat_out; s_oe = dat_oe; s_rd = rd_data; s_rv = rd_valid;
        s_done = done; s_busy = busy;
    endtask

    task automatic start_xfer(input bit wr, input bit w, input int rep, input int nb,
                              input int gap);
        @(negedge clk);
        cfg_write = wr; cfg_wide = w; cfg_rep_m1 = 8'(rep);
        cfg_len_bits = 14'(nb * 8 + 15 * (w ? 4 : 1));
        cfg_gap = 6'(gap); cfg_tok_exp = 3'b010;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !rd_crc_ok && !wr_crc_ok, "R7 flags cleared at start", {busy, rd_crc_ok, wr_crc_ok}, 3'b100);
    endtask

    task automatic run_read(input bit w, input int nb, input int rep, input int bad_blk, input int bad_lane);
        int W = w ? 4 : 1;
        int L = nb * 8 / W;
        logic [15:0] crc [4];
        int got;
        start_xfer(0, w, rep, nb, 0);
        for (int b = 0; b <= rep; b++) begin
            for (int i = 0; i < 4; i++) blk_b[i] = gen(nb + W, b, i);
            dat_in = 4'hF; tick(); tick();
            for (int l = 0; l < 4; l++) crc[l] = '0;
            dat_in = w ? 4'h0 : 4'hE;
            tick();
            got = 0;
            for (int t = 0; t < L; t++) begin
                for (int l = 0; l < 4; l++) begin
                    dat_in[l] = (l < W) ? line_bit(w, t, l) : 1'b1;
                    if (l < W) crc[l] = crc_upd(crc[l], dat_in[l]);
                end
                tick();
                if (s_rv) begin
                    chk(got < nb && s_rd == blk_b[got % 4], w ? "R4 read byte order" : "R6 read byte",
                        s_rd, blk_b[got % 4]);
                    got++;
                end
            end
            for (int k = 0; k < 16; k++) begin
                for (int l = 0; l < 4; l++) begin
                    dat_in[l] = (l < W) ? crc[l][15 - k] : 1'b1;
                    if (b == bad_blk && l == bad_lane && k == 5) dat_in[l] = ~dat_in[l];
                end
                tick();
                if (s_rv) got++;
            end
            chk(got == nb, "R2 payload byte count", got, nb);
            dat_in = 4'hF;
            tick();
            if (b == rep) begin
                chk(s_done && !s_busy, "R1 done after last block", {s_done, s_busy}, 2'b10);
                chk(rd_crc_ok == (bad_blk < 0) && !wr_crc_ok, "R7 read crc flag",
                    {rd_crc_ok, wr_crc_ok}, {(bad_blk < 0), 1'b0});
            end else begin
                chk(!s_done && s_busy, "R1 no early done", {s_done, s_busy}, 2'b01);
            end
        end
        tick();
        chk(rd_crc_ok == (bad_blk < 0), "R7 flag held", rd_crc_ok, (bad_blk < 0));
    endtask

    task automatic run_write(input bit w, input int nb, input int rep, input int gap,
                             input int bad_blk, input int busy_len);
        int W = w ? 4 : 1;
        int L = nb * 8 / W;
        logic [3:0] mask = w ? 4'hF : 4'h1;
        logic [15:0] crc [4];
        logic [3:0] expv;
        logic [2:0] tok;
        int cnt, errs;
        for (int i = 0; i < 16; i++) wmem[i] = gen(gap + nb, i / 4, i);
        widx = 0;
        start_xfer(1, w, rep, nb, gap);
        repeat (4) @(negedge clk);
        chk(dat_oe == 4'h0 && widx == 0 && dat_out == 4'hF, "R11 idle without tick", {dat_oe, 4'(widx)}, 0);
        for (int b = 0; b <= rep; b++) begin
            for (int i = 0; i < nb; i++) blk_b[i] = wmem[b * nb + i];
            dat_in = 4'hF;
            cnt = 0;
            tick();
            while (s_oe == 4'h0 && cnt < 80) begin
                cnt++;
                tick();
            end
            chk(cnt == gap, "R8 gap length", cnt, gap);
            chk(s_oe == mask, w ? "R4 output enable" : "R3 output enable", s_oe, mask);
            chk((s_out & mask) == 4'h0, "R5 start bit", s_out, 0);
            for (int l = 0; l < 4; l++) crc[l] = '0;
            errs = 0;
            for (int t = 0; t < L; t++) begin
                tick();
                for (int l = 0; l < 4; l++) begin
                    expv[l] = (l < W) ? line_bit(w, t, l) : 1'b1;
                    if (l < W) crc[l] = crc_upd(crc[l], expv[l]);
                end
                if ((s_out & mask) != (expv & mask)) begin
                    errs++;
                    chk(0, w ? "R4 nibble data" : "R3 serial data", s_out & mask, expv & mask);
                end
            end
            chk(errs == 0, w ? "R4 block payload" : "R3 block payload", errs, 0);
            errs = 0;
            for (int k = 0; k < 16; k++) begin
                tick();
                for (int l = 0; l < 4; l++) expv[l] = (l < W) ? crc[l][15 - k] : 1'b1;
                if ((s_out & mask) != (expv & mask)) begin
                    errs++;
                    chk(0, "R5 crc bit", s_out & mask, expv & mask);
                end
            end
            chk(errs == 0, "R5 crc field", errs, 0);
            tick();
            chk((s_out & mask) == mask && s_oe == mask, "R5 end bit", {s_out, s_oe}, {mask, mask});
            chk(widx == (b + 1) * nb, "R11 one pop per byte", widx, (b + 1) * nb);
            tick();
            chk(s_oe == 4'h0, "R9 bus released", s_oe, 0);
            dat_in = 4'hE; tick();
            tok = (b == bad_blk) ? 3'b101 : 3'b010;
            for (int i = 2; i >= 0; i--) begin
                dat_in = {3'b111, tok[i]};
                tick();
            end
            dat_in = 4'hF; tick();
            for (int i = 0; i < busy_len; i++) begin
                dat_in = 4'hE;
                tick();
                chk(s_busy && !s_done && s_oe == 0, "R10 wait while busy", {s_busy, s_done, s_oe}, 6'b100000);
            end
            dat_in = 4'hF;
            tick();
            if (b == rep) begin
                chk(s_done && !s_busy, "R1 write done", {s_done, s_busy}, 2'b10);
                chk(wr_crc_ok == (bad_blk < 0) && !rd_crc_ok, "R9 write token flag",
                    {wr_crc_ok, rd_crc_ok}, {(bad_blk < 0), 1'b0});
            end else begin
                chk(!s_done && s_busy, "R10 continues after busy", {s_done, s_busy}, 2'b01);
            end
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        summary();
    end

    initial begin
        int sizes [3] = '{1, 2, 4};
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && dat_oe == 0 && dat_out == 4'hF && !done && !rd_valid && !rd_crc_ok && !wr_crc_ok,
            "R12 reset state", {busy, dat_oe, dat_out, done, rd_valid, rd_crc_ok, wr_crc_ok},
            {1'b0, 4'h0, 4'hF, 4'h0});
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 3; s++)
                for (int rep = 0; rep < 3; rep += 2)
                    run_read(w[0], sizes[s], rep, -1, 0);
        run_read(1, 2, 2, 1, 3);
        run_read(1, 1, 0, 0, 0);
        run_read(0, 2, 1, 0, 0);
        run_read(1, 4, 1, 1, 2);
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 3; s++)
                for (int rep = 0; rep < 3; rep += 2)
                    run_write(w[0], sizes[s], rep, (sizes[s] + rep + w) % 4, -1, rep);
        run_write(1, 2, 2, 1, 1, 2);
        run_write(0, 1, 0, 2, 0, 0);
        run_write(0, 2, 1, 0, 1, 3);
        summary();
    end
endmodule